// File: doc/BRIEF.md
# Control Register Access Validator

This block sits beside a processor's control register file and decides, for each move to or from a control register, whether the move may go ahead or must trap. Each request carries a register index, a direction, write data, the privilege level, the execution mode, a LOCK-prefix flag and a capability bit. Long-mode enable and long-mode active status arrive as inputs. The block keeps copies of CR0, CR3, CR4 and CR8 itself.

One cycle after a request, the block returns a response. The response holds an allow strobe, a single fault code, the effective register index after any alias, and the read data for an allowed read. A register changes only when a write is allowed. The checks cover consistency between the paging, protection, cache and long-mode enables, as well as reserved bits. In legacy mode, a LOCK prefix on index 0 reaches CR8 instead.

Top module: `crv_top`

## Requirements
- R1: Every request with `req_valid` high produces exactly one response with `resp_valid` high on the next clock edge. Fault codes are 0 for none, 1 for invalid opcode and 2 for general protection. `resp_allow` is high only with code 0. With no response, allow and fault are 0.
- R2: An effective index of 1, 5, 6, 7 or 9 to 15 gives fault code 1.
- R3: In legacy mode (`mode64`=0), LOCK with index 0 gives effective index 8. LOCK in 64-bit mode, or LOCK with any other index, gives fault code 1. The alias itself gives fault code 1 when `alias_cap` is 0.
- R4: A privilege level other than 0 gives fault code 2.
- R5: A write that sets a reserved bit gives fault code 2. The writable bits are listed below; every other bit is reserved.
  - CR0: bits 0 to 5, bit 16, bit 18 and bits 29 to 31.
  - CR3: bits 3, 4 and 12 to 51.
  - CR4: bits 0 to 10.
  - CR8: bits 0 to 3.
- R6: A CR0 write with bit 31 (paging) set and bit 0 (protection) clear gives fault code 2.
- R7: A CR0 write with bit 30 (cache disable) clear and bit 29 (not write-through) set gives fault code 2.
- R8: A CR0 write that sets bit 31 while `efer_lme`=1 and the held CR4 bit 5 (PAE) is 0 gives fault code 2.
- R9: A CR4 write with bit 5 clear while `efer_lma`=1 gives fault code 2.
- R10: When both an invalid-opcode cause and a general-protection cause apply, the fault code is 1.
- R11: A rejected access leaves all four registers unchanged. Its `resp_rdata` is 0.
- R12: After reset, CR0 is 64'h6000_0010 and CR3, CR4 and CR8 are 0. An allowed write takes effect for the next request. An allowed read returns the value the register held when it was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write to register, 0 = read |
| req_idx | input | 4 | Requested register index |
| req_wdata | input | 64 | Write data |
| req_cpl | input | 2 | Current privilege level |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy |
| req_lock | input | 1 | LOCK prefix present |
| alias_cap | input | 1 | Legacy LOCK alias to CR8 supported |
| efer_lme | input | 1 | Long mode enabled |
| efer_lma | input | 1 | Long mode active |
| resp_valid | output | 1 | Response present |
| resp_allow | output | 1 | Access allowed |
| resp_fault | output | 2 | Fault code |
| resp_idx | output | 4 | Effective register index |
| resp_rdata | output | 64 | Read data for an allowed read |

## Verification
The bench targets the LOCK alias on both sides of its boundary: LOCK in 64-bit mode, LOCK on a non-zero index, and the alias with the capability bit off. A design that got any of these wrong would either reach CR8 when it should trap, or trap a legal CR8 access. Cases where an undefined-index cause and a privilege cause both apply check fault priority; a wrong priority reports code 2. Each cross-register rule is checked by attempting a rejected write and then reading the register back. A design that committed before checking would return the new value. Paging is then enabled once PAE is set, which shows that the R8 check reads the held CR4 rather than a stale value.

// File: rtl/crv_pkg.sv
package crv_pkg;
  localparam int unsigned CRV_XLEN  = 64;
  localparam int unsigned CRV_IDX_W = 4;
  localparam int unsigned CRV_CPL_W = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } crv_fault_e;

  localparam logic [CRV_XLEN-1:0] CR0_WRITABLE = 64'h0000_0000_E005_003F;
  localparam logic [CRV_XLEN-1:0] CR3_WRITABLE = 64'h000F_FFFF_FFFF_F018;
  localparam logic [CRV_XLEN-1:0] CR4_WRITABLE = 64'h0000_0000_0000_07FF;
  localparam logic [CRV_XLEN-1:0] CR8_WRITABLE = 64'h0000_0000_0000_000F;
  localparam logic [CRV_XLEN-1:0] CR0_RESET    = 64'h0000_0000_6000_0010;

  localparam int unsigned B_PE  = 0;
  localparam int unsigned B_NW  = 29;
  localparam int unsigned B_CD  = 30;
  localparam int unsigned B_PG  = 31;
  localparam int unsigned B_PAE = 5;
endpackage

// File: rtl/crv_decode.sv
module crv_decode
  import crv_pkg::*;
#(
  parameter int unsigned IDX_W = CRV_IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             lock,
  input  logic             mode64,
  input  logic             alias_cap,
  output logic [IDX_W-1:0] eff_idx,
  output logic             ud
);
  localparam logic [IDX_W-1:0] ALIAS_IDX = IDX_W'(8);

  logic is_alias;
  logic bad_lock;
  logic legal;

  always_comb begin
    is_alias = lock && !mode64 && (idx == '0);
    bad_lock = lock && !is_alias;
    eff_idx  = is_alias ? ALIAS_IDX : idx;
    legal    = (eff_idx == IDX_W'(0)) || (eff_idx == IDX_W'(2)) ||
               (eff_idx == IDX_W'(3)) || (eff_idx == IDX_W'(4)) ||
               (eff_idx == ALIAS_IDX);
    ud       = bad_lock || (is_alias && !alias_cap) || !legal;
  end
endmodule

// File: rtl/crv_rules.sv
module crv_rules
  import crv_pkg::*;
#(
  parameter int unsigned DATA_W = CRV_XLEN,
  parameter int unsigned IDX_W  = CRV_IDX_W,
  parameter int unsigned CPL_W  = CRV_CPL_W
) (
  input  logic [IDX_W-1:0]  eff_idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CPL_W-1:0]  cpl,
  input  logic              pae_now,
  input  logic              lme,
  input  logic              lma,
  output logic              gp
);
  logic rsv_hit;
  logic cr0_bad;
  logic cr4_bad;

  always_comb begin
    unique case (eff_idx)
      IDX_W'(0): rsv_hit = |(wdata & ~DATA_W'(CR0_WRITABLE));
      IDX_W'(3): rsv_hit = |(wdata & ~DATA_W'(CR3_WRITABLE));
      IDX_W'(4): rsv_hit = |(wdata & ~DATA_W'(CR4_WRITABLE));
      IDX_W'(8): rsv_hit = |(wdata & ~DATA_W'(CR8_WRITABLE));
      default:   rsv_hit = 1'b0;
    endcase
    cr0_bad = (eff_idx == IDX_W'(0)) &&
              ((wdata[B_PG] && !wdata[B_PE]) ||
               (!wdata[B_CD] && wdata[B_NW]) ||
               (wdata[B_PG] && lme && !pae_now));
    cr4_bad = (eff_idx == IDX_W'(4)) && !wdata[B_PAE] && lma;
    gp      = (cpl != '0) || (wr && (rsv_hit || cr0_bad || cr4_bad));
  end
endmodule

// File: rtl/crv_regs.sv
module crv_regs
  import crv_pkg::*;
#(
  parameter int unsigned DATA_W = CRV_XLEN,
  parameter int unsigned IDX_W  = CRV_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cr0,
  output logic [DATA_W-1:0] cr3,
  output logic [DATA_W-1:0] cr4,
  output logic [DATA_W-1:0] cr8
);
  logic [DATA_W-1:0] cr0_d, cr3_d, cr4_d, cr8_d;

  always_comb begin
    cr0_d = cr0;
    cr3_d = cr3;
    cr4_d = cr4;
    cr8_d = cr8;
    if (wr_en) begin
      unique case (wr_idx)
        IDX_W'(0): cr0_d = wr_data;
        IDX_W'(3): cr3_d = wr_data;
        IDX_W'(4): cr4_d = wr_data;
        IDX_W'(8): cr8_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0 <= DATA_W'(CR0_RESET);
      cr3 <= '0;
      cr4 <= '0;
      cr8 <= '0;
    end else if (wr_en) begin
      cr0 <= cr0_d;
      cr3 <= cr3_d;
      cr4 <= cr4_d;
      cr8 <= cr8_d;
    end
  end

  assert_pg_needs_pe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cr0[B_PG] |-> cr0[B_PE]);
  assert_nw_needs_cd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cr0[B_CD] |-> !cr0[B_NW]);
endmodule

// File: rtl/crv_top.sv
module crv_top
  import crv_pkg::*;
#(
  parameter int unsigned DATA_W = CRV_XLEN,
  parameter int unsigned IDX_W  = CRV_IDX_W,
  parameter int unsigned CPL_W  = CRV_CPL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic              mode64,
  input  logic              req_lock,
  input  logic              alias_cap,
  input  logic              efer_lme,
  input  logic              efer_lma,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic [1:0]        resp_fault,
  output logic [IDX_W-1:0]  resp_idx,
  output logic [DATA_W-1:0] resp_rdata
);
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [IDX_W-1:0]  eff_idx;
  logic              ud, gp;
  logic [DATA_W-1:0] cr0, cr3, cr4, cr8;

  crv_decode #(.IDX_W(IDX_W)) decode_i (
    .idx(req_idx), .lock(req_lock), .mode64(mode64), .alias_cap(alias_cap),
    .eff_idx(eff_idx), .ud(ud)
  );

  crv_rules #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CPL_W(CPL_W)) rules_i (
    .eff_idx(eff_idx), .wr(req_write), .wdata(req_wdata), .cpl(req_cpl),
    .pae_now(cr4[B_PAE]), .lme(efer_lme), .lma(efer_lma), .gp(gp)
  );

  crv_fault_e        fault_d;
  logic              allow_d;
  logic              wr_en;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    if (!req_valid)  fault_d = FLT_NONE;
    else if (ud)     fault_d = FLT_UD;
    else if (gp)     fault_d = FLT_GP;
    else             fault_d = FLT_NONE;
    allow_d = req_valid && (fault_d == FLT_NONE);
    wr_en   = allow_d && req_write;
    rdata_d = '0;
    if (allow_d && !req_write) begin
      unique case (eff_idx)
        IDX_W'(0): rdata_d = cr0;
        IDX_W'(3): rdata_d = cr3;
        IDX_W'(4): rdata_d = cr4;
        IDX_W'(8): rdata_d = cr8;
        default:   rdata_d = '0;
      endcase
    end
  end

  crv_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_idx(eff_idx),
    .wr_data(req_wdata), .cr0(cr0), .cr3(cr3), .cr4(cr4), .cr8(cr8)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_fault <= FLT_NONE;
      resp_idx   <= '0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= allow_d;
      resp_fault <= fault_d;
      resp_idx   <= req_valid ? eff_idx : '0;
      resp_rdata <= rdata_d;
    end
  end

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_q)
    !resp_valid |-> (!resp_allow && resp_fault == 2'd0));
  assert_bad_index_ud_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !req_lock && !(req_idx inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd8}))
    |=> (resp_fault == 2'd1));
  assert_nonzero_cpl_faults_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_cpl != '0) |=> (!resp_allow && resp_fault != 2'd0));
  assert_reject_holds_regs_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (resp_valid && !resp_allow) |->
      ({cr0, cr3, cr4, cr8} == $past({cr0, cr3, cr4, cr8})));
endmodule

// File: tb/crv_top_tb_top.sv
module crv_top_tb_top;
  localparam int XW = 64;
  typedef logic [1+2+4+XW-1:0] item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]    req_idx = '0;
  logic [XW-1:0] req_wdata = '0;
  logic [1:0]    req_cpl = '0;
  logic          mode64 = 1'b0, req_lock = 1'b0, alias_cap = 1'b1;
  logic          efer_lme = 1'b0, efer_lma = 1'b0;
  logic          resp_valid, resp_allow;
  logic [1:0]    resp_fault;
  logic [3:0]    resp_idx;
  logic [XW-1:0] resp_rdata;

  crv_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .req_cpl(req_cpl),
    .mode64(mode64), .req_lock(req_lock), .alias_cap(alias_cap),
    .efer_lme(efer_lme), .efer_lma(efer_lma), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .resp_fault(resp_fault), .resp_idx(resp_idx),
    .resp_rdata(resp_rdata)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  string tag_q[$];

  logic [XW-1:0] m_cr0 = 64'h6000_0010, m_cr3 = '0, m_cr4 = '0, m_cr8 = '0;

  task automatic access(input logic [3:0] idx, input logic wr,
                        input logic [XW-1:0] data, input logic [1:0] cpl,
                        input logic lock, input string tag);
    logic alias_hit, ud, gp, rsv;
    logic [3:0] eff;
    logic [1:0] flt;
    logic [XW-1:0] rd;
    @(negedge clk);
    alias_hit = lock && !mode64 && idx == 4'd0;
    eff = alias_hit ? 4'd8 : idx;
    ud = (lock && !alias_hit) || (alias_hit && !alias_cap) ||
         !(eff inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd8});
    case (eff)
      4'd0: rsv = |(data & ~64'h0000_0000_E005_003F);
      4'd3: rsv = |(data & ~64'h000F_FFFF_FFFF_F018);
      4'd4: rsv = |(data & ~64'h0000_0000_0000_07FF);
      4'd8: rsv = |(data & ~64'h0000_0000_0000_000F);
      default: rsv = 1'b0;
    endcase
    gp = (cpl != 2'd0) || (wr && (rsv ||
         (eff == 4'd0 && ((data[31] && !data[0]) || (!data[30] && data[29]) ||
                          (data[31] && efer_lme && !m_cr4[5]))) ||
         (eff == 4'd4 && !data[5] && efer_lma)));
    flt = ud ? 2'd1 : (gp ? 2'd2 : 2'd0);
    rd = '0;
    if (flt == 2'd0 && !wr)
      case (eff)
        4'd0: rd = m_cr0;
        4'd3: rd = m_cr3;
        4'd4: rd = m_cr4;
        default: rd = m_cr8;
      endcase
    if (flt == 2'd0 && wr)
      case (eff)
        4'd0: m_cr0 = data;
        4'd3: m_cr3 = data;
        4'd4: m_cr4 = data;
        default: m_cr8 = data;
      endcase
    exp_q.push_back({flt == 2'd0, flt, eff, rd});
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = data;
    req_cpl = cpl; req_lock = lock;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_lock = 1'b0; req_cpl = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      item_t e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected response allow=%0b fault=%0d expected none",
                 resp_allow, resp_fault);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({resp_allow, resp_fault, resp_idx, resp_rdata} !== e) begin
          errors++;
          $display("FAIL %s: got allow=%0b fault=%0d idx=%0d rdata=%h expected allow=%0b fault=%0d idx=%0d rdata=%h",
                   t, resp_allow, resp_fault, resp_idx, resp_rdata,
                   e[70], e[69:68], e[67:64], e[63:0]);
        end
      end
    end
  end

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || resp_allow !== 1'b0 || resp_fault !== 2'd0) begin
      errors++;
      $display("FAIL R1: reset outputs v=%0b a=%0b f=%0d expected 0 0 0",
               resp_valid, resp_allow, resp_fault);
    end
    mode64 = 1'b1;
    access(4'd0, 0, '0, 0, 0, "R12");
    access(4'd3, 0, '0, 0, 0, "R12");
    access(4'd1, 0, '0, 0, 0, "R2");
    access(4'd6, 1, '0, 0, 0, "R2");
    access(4'd9, 0, '0, 0, 0, "R2");
    access(4'd15, 0, '0, 0, 0, "R2");
    access(4'd3, 1, 64'h0000_0001_2345_6018, 0, 0, "R12");
    access(4'd3, 0, '0, 0, 0, "R12");
    access(4'd3, 1, 64'h0000_0001_2345_6019, 0, 0, "R5");
    access(4'd3, 0, '0, 0, 0, "R11");
    access(4'd0, 0, '0, 3, 0, "R4");
    access(4'd0, 1, 64'h11, 1, 0, "R4");
    access(4'd5, 0, '0, 3, 0, "R10");
    access(4'd0, 1, 64'h8000_0000, 0, 0, "R6");
    access(4'd0, 1, 64'h2000_0001, 0, 0, "R7");
    access(4'd0, 0, '0, 0, 0, "R11");
    access(4'd0, 1, 64'h11, 0, 0, "R12");
    access(4'd0, 0, '0, 0, 0, "R12");
    idle();
    efer_lme = 1'b1;
    access(4'd0, 1, 64'h8000_0011, 0, 0, "R8");
    access(4'd4, 1, 64'h20, 0, 0, "R12");
    access(4'd0, 1, 64'h8000_0011, 0, 0, "R8");
    access(4'd0, 0, '0, 0, 0, "R8");
    idle();
    efer_lma = 1'b1;
    access(4'd4, 1, 64'h0, 0, 0, "R9");
    access(4'd4, 0, '0, 0, 0, "R11");
    access(4'd4, 1, 64'h21, 0, 0, "R9");
    access(4'd4, 1, 64'h821, 0, 0, "R5");
    access(4'd8, 1, 64'h10, 0, 0, "R5");
    access(4'd8, 1, 64'h7, 0, 0, "R12");
    access(4'd0, 0, '0, 0, 1, "R3");
    access(4'd0, 1, 64'h0, 2, 0, "R4");
    idle();
    mode64 = 1'b0;
    access(4'd0, 1, 64'h5, 0, 1, "R3");
    access(4'd0, 0, '0, 0, 1, "R3");
    access(4'd8, 0, '0, 0, 0, "R3");
    access(4'd3, 0, '0, 0, 1, "R3");
    access(4'd0, 0, '0, 0, 0, "R3");
    idle();
    alias_cap = 1'b0;
    access(4'd0, 0, '0, 0, 1, "R3");
    access(4'd0, 1, 64'hFF, 3, 1, "R10");
    access(4'd8, 0, '0, 0, 0, "R11");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule